// File: doc/BRIEF.md
# SPI Register-Access Command Engine

This block is the host side of a register-access path to an Ethernet MAC-PHY over SPI. A requester gives it one command at a time: a 20-bit register address, a direction flag, a register count (1 to 128, written as count minus one), a protection flag and the write data words. The engine builds a 32-bit control header with an odd parity bit. It drives chip select low for the whole transaction and clocks the header out in SPI mode 0, most-significant bit first. It then sends the write data, or zero filler for a read, and ends with one extra zero word, because the device answers one word late.

While it transmits, the engine shifts in the receive stream. It throws away the first received word. The second received word must be the echo of the header; any difference raises a header error. The received words after that carry the register data. On a read these words are handed to the requester one at a time with their index. In protected mode every data word travels with its bitwise complement in the following word. A received complement that does not match sets a data error, but the data word is still delivered. A one-cycle done pulse ends each transaction, and the error flags hold their value until the next command is accepted.

Top module: `spi_regcmd_engine`

## Requirements
- R1: The header word is built as follows. Bit 31 (data/control select) is 0, bit 30 is 0, bit 29 is 1 for a write and 0 for a read, and bit 28 (address ID) is 0. Bits 27:24 are address bits 19:16 and bits 23:8 are address bits 15:0. Bits 7:1 carry `reqLenM1`, the register count minus one.
- R2: Header bit 0 is set so that the 32-bit header holds an odd number of ones.
- R3: SPI runs in mode 0. `sclk` is low whenever `csN` is high, `mosi` changes only while `sclk` is low, and each word is sent MSB first. `csN` stays low from the first bit to the last bit of a transaction.
- R4: A transaction moves 2+n words when unprotected and 2+2n words when protected, where n = `reqLenM1`+1. The data slots of a read and the final word are all zero.
- R5: A write sends the write words in register order. In protected mode each write word is followed directly by its bitwise complement. `wdNext` pulses once after each write word is taken, and the requester then presents the next word on `wrData`.
- R6: The first received word is ignored. If the second received word differs from the transmitted header, `errHdr` is 1 at done.
- R7: On a read, the received data word for register i appears on `rdData` with `rdIndex`=i and a one-cycle `rdValid`, in order for i = 0..n-1. A write produces no `rdValid`.
- R8: In protected mode, if a received complement word is not the bitwise inverse of the data word before it, `errData` is 1 at done. The read data is still delivered.
- R9: `done` pulses for exactly one cycle, in the first cycle after the transaction in which `busy` is low. A `start` while `busy` is high is ignored: no second transaction begins, and the fields of the running command do not change.
- R10: After reset, `csN`=1, `sclk`=0, `busy`=0, `done`=0, `rdValid`=0 and `wdNext`=0.
- R11: A count of 128 registers (`reqLenM1`=127) is carried out in full: 130 words are moved and 128 read words are returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| reqAddr | input | 20 | Register address: selector in bits 19:16, offset in bits 15:0 |
| reqWrite | input | 1 | 1 = write registers, 0 = read registers |
| reqLenM1 | input | 7 | Number of consecutive registers minus one |
| reqProt | input | 1 | 1 = each data word is followed by its complement |
| wrData | input | 32 | Current write data word |
| wdNext | output | 1 | Pulse: current write word taken, present the next one |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| errHdr | output | 1 | Echoed header mismatch in the last transaction |
| errData | output | 1 | Complement mismatch in the last transaction |
| rdValid | output | 1 | Read data word valid |
| rdIndex | output | 7 | Register index of the read word |
| rdData | output | 32 | Read data word |
| sclk | output | 1 | SPI clock, idle low |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |

## Verification
The bench models the device on the SPI wires: it echoes each word one slot late and keeps a register store. It aims at the word-lag alignment. An engine that was off by one word would compare the header against the wrong word and deliver read data shifted or into the wrong index. It drives a single-register command and a 128-register command. These catch a length field sent as the count itself, or a word counter that ends one word early or late. It corrupts the echoed header and one protected complement, which exposes a check that is missing or points at the wrong word, and a design that drops the data when the complement is bad. It also raises `start` in the middle of a transaction. An engine that relatches there would send a changed header or start a second chip-select window.

// File: rtl/ctlcmd_pkg.sv
package ctlcmd_pkg;
  localparam int ADDR_W   = 20;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 7;
  localparam int MAX_REGS = 1 << LEN_W;
  localparam int IDX_W    = $clog2(2 * MAX_REGS + 2);

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_LOW, ST_HIGH, ST_FIN} ctlState_t;

  typedef struct packed {
    logic latch;
    logic load;
    logic sample;
    logic shift;
    logic wordEnd;
  } ctlStrobe_t;

  function automatic logic [WORD_W-1:0] buildHeader(input logic wnr,
                                                    input logic [ADDR_W-1:0] addr,
                                                    input logic [LEN_W-1:0] lenM1);
    logic [WORD_W-1:0] h;
    h = '0;
    h[29]    = wnr;
    h[27:24] = addr[19:16];
    h[23:8]  = addr[15:0];
    h[7:1]   = lenM1;
    h[0]     = ~(^h[31:1]);
    return h;
  endfunction
endpackage

// File: rtl/ctlcmd_ctrl.sv
module ctlcmd_ctrl
  import ctlcmd_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] lastIdx,
  output ctlStrobe_t       strb,
  output logic [IDX_W-1:0] wordIdx,
  output logic             sclk,
  output logic             csN,
  output logic             busy,
  output logic             done
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  ctlState_t  st;
  logic [DIV_W-1:0] divCnt;
  logic [4:0] bitIdx;
  logic divDone;

  assign divDone = (divCnt == DIV_W'(CLK_DIV - 1));
  assign busy    = (st != ST_IDLE);

  always_comb begin
    strb.latch   = (st == ST_IDLE) && start;
    strb.load    = (st == ST_LOAD);
    strb.sample  = (st == ST_LOW) && divDone;
    strb.shift   = (st == ST_HIGH) && divDone && (bitIdx != 5'd31);
    strb.wordEnd = (st == ST_HIGH) && divDone && (bitIdx == 5'd31);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      divCnt  <= '0;
      bitIdx  <= '0;
      wordIdx <= '0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (strb.latch) begin
            st      <= ST_LOAD;
            wordIdx <= '0;
          end
        end
        ST_LOAD: begin
          csN    <= 1'b0;
          divCnt <= '0;
          bitIdx <= '0;
          st     <= ST_LOW;
        end
        ST_LOW: begin
          if (strb.sample) begin
            sclk   <= 1'b1;
            divCnt <= '0;
            st     <= ST_HIGH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (divDone) begin
            sclk   <= 1'b0;
            divCnt <= '0;
            if (strb.shift) begin
              bitIdx <= bitIdx + 1'b1;
              st     <= ST_LOW;
            end else if (wordIdx == lastIdx) begin
              csN <= 1'b1;
              st  <= ST_FIN;
            end else begin
              wordIdx <= wordIdx + 1'b1;
              st      <= ST_LOAD;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: the clock never toggles outside the chip-select window
  a_r3_clock_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R9: done comes exactly once, right as busy drops
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/ctlcmd_dpath.sv
module ctlcmd_dpath
  import ctlcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [LEN_W-1:0]  reqLenM1,
  input  logic              reqProt,
  input  logic [WORD_W-1:0] wrData,
  input  logic              miso,
  output logic [IDX_W-1:0]  lastIdx,
  output logic              mosi,
  output logic              wdNext,
  output logic              rdValid,
  output logic [LEN_W-1:0]  rdIndex,
  output logic [WORD_W-1:0] rdData,
  output logic              errHdr,
  output logic              errData
);
  logic [ADDR_W-1:0] addrR;
  logic              writeR, protR;
  logic [LEN_W-1:0]  lenR;
  logic [WORD_W-1:0] txSh, rxSh, wdHold, rdHold, hdrWord, txWord;
  logic [IDX_W-1:0]  nRegs, dataWords, txSlot, rxSlot, txRegFull, rxRegFull;
  logic              txData, txComp, rxData, rxComp;

  assign hdrWord   = buildHeader(writeR, addrR, lenR);
  assign nRegs     = IDX_W'(lenR) + IDX_W'(1);
  assign dataWords = protR ? (nRegs << 1) : nRegs;
  assign lastIdx   = dataWords + IDX_W'(1);
  assign mosi      = txSh[WORD_W-1];

  assign txSlot    = wordIdx - IDX_W'(1);
  assign txData    = (wordIdx != '0) && (txSlot < dataWords);
  assign txComp    = protR & txSlot[0];
  assign txRegFull = protR ? (txSlot >> 1) : txSlot;

  assign rxSlot    = wordIdx - IDX_W'(2);
  assign rxData    = (wordIdx >= IDX_W'(2)) && (rxSlot < dataWords);
  assign rxComp    = protR & rxSlot[0];
  assign rxRegFull = protR ? (rxSlot >> 1) : rxSlot;

  always_comb begin
    if (wordIdx == '0)         txWord = hdrWord;
    else if (txData && writeR) txWord = txComp ? ~wdHold : wrData;
    else                       txWord = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR   <= '0;
      writeR  <= 1'b0;
      protR   <= 1'b0;
      lenR    <= '0;
      txSh    <= '0;
      rxSh    <= '0;
      wdHold  <= '0;
      rdHold  <= '0;
      wdNext  <= 1'b0;
      rdValid <= 1'b0;
      rdIndex <= '0;
      rdData  <= '0;
      errHdr  <= 1'b0;
      errData <= 1'b0;
    end else begin
      wdNext  <= 1'b0;
      rdValid <= 1'b0;
      if (strb.latch) begin
        addrR   <= reqAddr;
        writeR  <= reqWrite;
        protR   <= reqProt;
        lenR    <= reqLenM1;
        errHdr  <= 1'b0;
        errData <= 1'b0;
      end
      if (strb.load) begin
        txSh <= txWord;
        if (txData && writeR && !txComp) begin
          wdHold <= wrData;
          wdNext <= 1'b1;
        end
      end
      if (strb.shift) txSh <= {txSh[WORD_W-2:0], 1'b0};
      if (strb.sample) rxSh <= {rxSh[WORD_W-2:0], miso};
      if (strb.wordEnd) begin
        if ((wordIdx == IDX_W'(1)) && (rxSh != hdrWord)) errHdr <= 1'b1;
        if (rxData) begin
          if (rxComp) begin
            if (rxSh != ~rdHold) errData <= 1'b1;
          end else begin
            rdHold <= rxSh;
            if (!writeR) begin
              rdValid <= 1'b1;
              rdIndex <= rxRegFull[LEN_W-1:0];
              rdData  <= rxSh;
            end
          end
        end
      end
    end
  end

  // R2: the header loaded into the shifter has odd weight
  a_r2_odd_header: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && wordIdx == '0) |=> ($countones(txSh) % 2 == 1));

  // R5: write words are only requested on writes
  a_r5_fetch_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wdNext |-> writeR);

  // R7: read words are only delivered on reads
  a_r7_deliver_on_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !writeR);

  // R9: command fields stay put between acceptances
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> $stable(addrR) && $stable(lenR) && $stable(writeR));
endmodule

// File: rtl/spi_regcmd_engine.sv
module spi_regcmd_engine
  import ctlcmd_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [LEN_W-1:0]  reqLenM1,
  input  logic              reqProt,
  input  logic [WORD_W-1:0] wrData,
  output logic              wdNext,
  output logic              busy,
  output logic              done,
  output logic              errHdr,
  output logic              errData,
  output logic              rdValid,
  output logic [LEN_W-1:0]  rdIndex,
  output logic [WORD_W-1:0] rdData,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  ctlStrobe_t       strb;
  logic [IDX_W-1:0] wordIdx, lastIdx;

  ctlcmd_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastIdx(lastIdx),
    .strb(strb), .wordIdx(wordIdx), .sclk(sclk), .csN(csN),
    .busy(busy), .done(done)
  );

  ctlcmd_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqLenM1(reqLenM1),
    .reqProt(reqProt), .wrData(wrData), .miso(miso), .lastIdx(lastIdx),
    .mosi(mosi), .wdNext(wdNext), .rdValid(rdValid), .rdIndex(rdIndex),
    .rdData(rdData), .errHdr(errHdr), .errData(errData)
  );

  // R3: mode 0, data held steady across the high phase
  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: tb/tb_spi_regcmd_engine.sv
`timescale 1ns/1ps
module tb_spi_regcmd_engine;
  logic clk = 0, rstN = 0, start = 0, reqWrite = 0, reqProt = 0, miso;
  logic [19:0] reqAddr = 0;
  logic [6:0]  reqLenM1 = 0;
  logic [31:0] wrData = 0;
  logic wdNext, busy, done, errHdr, errData, rdValid, sclk, csN, mosi;
  logic [6:0]  rdIndex;
  logic [31:0] rdData;

  always #2.5 clk = ~clk;

  spi_regcmd_engine dut (.*);

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  bit [31:0] mem [int];
  bit [31:0] sWords[$];
  bit [31:0] sIn, respSh = 0, respNext = 0;
  int  sBit = 0, csFalls = 0;
  bit  sWr, sProt = 0, corruptHdr = 0;
  int  sAddr, sN, corruptIdx = -1;

  function automatic bit [31:0] memRd(int a);
    if (mem.exists(a)) return mem[a];
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic slaveWordDone();
    int j = sWords.size() - 1;
    int d, s;
    bit [31:0] v;
    if (j == 0) begin
      sWr   = sIn[29];
      sAddr = {sIn[27:24], sIn[23:8]};
      sN    = sIn[7:1] + 1;
      respNext = sIn ^ (corruptHdr ? 32'h100 : 32'h0);
      return;
    end
    d = sProt ? 2 * sN : sN;
    s = j - 1;
    if (sWr) begin
      if (s < d && (!sProt || s % 2 == 0)) mem[sAddr + (sProt ? s / 2 : s)] = sIn;
      respNext = sIn;
    end else if (s < d) begin
      v = memRd(sAddr + (sProt ? s / 2 : s));
      if (sProt && s % 2 == 1) respNext = ~v ^ ((s / 2 == corruptIdx) ? 32'h1 : 32'h0);
      else respNext = v;
    end else respNext = 0;
  endtask

  always @(negedge csN) begin
    sBit = 0; sWords.delete(); respSh = 32'hA5C30F1E; csFalls++;
  end
  always @(posedge sclk) if (!csN) begin
    sIn = {sIn[30:0], mosi}; sBit++;
    if (sBit == 32) begin sBit = 0; sWords.push_back(sIn); slaveWordDone(); end
  end
  always @(negedge sclk) if (!csN) begin
    if (sBit == 0) respSh = respNext; else respSh = {respSh[30:0], 1'b0};
  end
  assign miso = respSh[31];

  // ---------------- per-clock monitor ----------------
  int doneCnt = 0, wdIdx = 0, wireViol = 0;
  bit [31:0] wq[$];
  bit [38:0] rdQ[$];
  always @(negedge clk) if (rstN) begin
    if (done) doneCnt++;
    if (rdValid) rdQ.push_back({rdIndex, rdData});
    if (csN && sclk) wireViol++;
    if (!busy && !csN) wireViol++;
    if (wdNext) begin wdIdx++; wrData = (wdIdx < wq.size()) ? wq[wdIdx] : 32'h0; end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit [31:0] expHdr(bit wr, bit [19:0] a, int n);
    bit [31:0] h = 0;
    int c = 0;
    h[29] = wr; h[27:24] = a[19:16]; h[23:8] = a[15:0]; h[7:1] = 7'(n - 1);
    for (int i = 1; i < 32; i++) c += h[i];
    h[0] = (c % 2 == 0);
    return h;
  endfunction

  task automatic runTxn(input bit [19:0] a, input bit wr, input int n, input bit prot,
                        input bit cHdr, input int cIdx, input bit glitch, input string tag);
    bit [31:0] exp[$];
    bit [31:0] rexp[$];
    int falls0, d;
    d = prot ? 2 * n : n;
    sProt = prot; corruptHdr = cHdr; corruptIdx = cIdx;
    wq.delete();
    for (int i = 0; i < n; i++) wq.push_back(32'hC0DE0000 ^ (a << 4) ^ (i * 32'h01010101));
    rexp.delete();
    for (int i = 0; i < n; i++) rexp.push_back(memRd(a + i));
    exp.delete();
    exp.push_back(expHdr(wr, a, n));
    for (int i = 0; i < n; i++) begin
      exp.push_back(wr ? wq[i] : 32'h0);
      if (prot) exp.push_back(wr ? ~wq[i] : 32'h0);
    end
    exp.push_back(32'h0);
    rdQ.delete(); doneCnt = 0; wdIdx = 0; falls0 = csFalls;
    @(negedge clk);
    wrData = wq[0]; reqAddr = a; reqWrite = wr; reqLenM1 = 7'(n - 1); reqProt = prot; start = 1;
    @(negedge clk); start = 0;
    if (glitch) begin
      repeat (100) @(negedge clk);
      reqAddr = a ^ 20'h55; reqWrite = !wr; reqLenM1 = 7'(n + 3); start = 1;
      @(negedge clk); start = 0;
    end
    while (doneCnt == 0) @(negedge clk);
    chk(!busy, {tag, " R9 busy low at done"}, busy, 0);
    chk(errHdr == cHdr, {tag, " R6 header echo flag"}, errHdr, cHdr);
    chk(errData == (cIdx >= 0), {tag, " R8 complement flag"}, errData, cIdx >= 0);
    repeat (20) @(negedge clk);
    chk(doneCnt == 1, {tag, " R9 single done pulse"}, doneCnt, 1);
    chk(csFalls - falls0 == 1, {tag, " R9 one select window"}, csFalls - falls0, 1);
    chk(sWords.size() == d + 2, {tag, " R4 word count"}, sWords.size(), d + 2);
    if (sWords.size() > 0) begin
      chk(sWords[0] == exp[0], {tag, " R1 header fields"}, sWords[0], exp[0]);
      chk($countones(sWords[0]) % 2 == 1, {tag, " R2 odd parity"}, sWords[0], exp[0]);
    end
    for (int i = 1; i < exp.size() && i < sWords.size(); i++)
      if (sWords[i] != exp[i]) chk(0, {tag, wr ? " R5 write word" : " R4 filler word"}, sWords[i], exp[i]);
    chk(sWords.size() == exp.size() && sWords == exp, {tag, " R3 R5 stream content"}, sWords.size(), exp.size());
    if (wr) begin
      chk(rdQ.size() == 0, {tag, " R7 no read words on write"}, rdQ.size(), 0);
      chk(wdIdx == n, {tag, " R5 fetch pulses"}, wdIdx, n);
    end else begin
      chk(rdQ.size() == n, {tag, " R7 read word count"}, rdQ.size(), n);
      for (int i = 0; i < n && i < rdQ.size(); i++)
        if (rdQ[i] != {7'(i), rexp[i]}) chk(0, {tag, " R7 read word"}, rdQ[i], {7'(i), rexp[i]});
    end
    corruptHdr = 0; corruptIdx = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1 && sclk == 0, "R10 reset SPI idle", {csN, sclk}, 2'b10);
    chk(busy == 0 && done == 0, "R10 reset busy/done", {busy, done}, 0);
    chk(rdValid == 0 && wdNext == 0, "R10 reset strobes", {rdValid, wdNext}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    runTxn(20'h1_0020, 1, 3, 0, 0, -1, 0, "wr-unprot");
    runTxn(20'h1_0020, 0, 3, 0, 0, -1, 0, "rd-unprot");
    runTxn(20'h3_0400, 1, 2, 1, 0, -1, 0, "wr-prot");
    runTxn(20'h3_0400, 0, 2, 1, 0, -1, 0, "rd-prot");
    runTxn(20'h3_0400, 0, 2, 1, 0, 1, 0, "rd-prot-badcomp R8");
    runTxn(20'h2_1234, 0, 1, 0, 1, -1, 0, "rd-badecho R6");
    runTxn(20'hA_0008, 1, 4, 0, 0, -1, 1, "wr-startwhilebusy R9");
    runTxn(20'hF_FF00, 0, 128, 0, 0, -1, 0, "rd-max R11");
    runTxn(20'h5_0001, 0, 1, 1, 0, -1, 0, "rd-single-prot");
    chk(wireViol == 0, "R3 R10 select/clock relation every clock", wireViol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule